// File: doc/BRIEF.md
# Alarm and Periodic Interrupt Unit

This block raises interrupts next to a free-running elapsed-time counter. It has no counter of its own. It watches the live seconds count and the fractional count, which has 4096 ticks per second by default, and a strobe that marks each advance of the fractional count. It holds a 32-bit alarm time. When the seconds count reaches that time, a sticky alarm flag sets.

The block also raises a sticky periodic flag at a programmable rate. That rate is taken from the low bits of the same counter. A host that loads the counter therefore moves the moments at which the periodic flag sets.

The host reaches the alarm bytes, two control bytes and a status byte through a small byte-wide register port. Each flag has its own enable. The active-low interrupt output is asserted while any enabled flag is set. A flag is cleared by writing 0 to its status bit.

Top module: `tirq_unit`

## Requirements
- R1: The alarm time is stored in four byte registers at addresses 6 to 9, least significant byte at address 6. Each byte reads back on `reg_rdata` in the same cycle its address is presented.
- R2: At the clock edge that ends a cycle with `tick` or `cnt_load` high and `sec_cnt` equal to the alarm time, the alarm flag (status address 0Ch, bit 0) sets.
- R3: A write to any alarm byte causes one extra compare at the following edge. If the counter already equals the new alarm time, the alarm flag sets without waiting for a tick.
- R4: The rate field is bits 7:4 of address 0Bh. For a value n from 1 to 12, the periodic flag (status bit 1) sets at the edge that ends a tick cycle in which the fractional count is a multiple of 2^(n-1).
- R5: Rate values 13, 14 and 15 set the periodic flag on a tick where the fractional count is 0 and the seconds count is a multiple of 1, 2 and 4 respectively. A rate of 0 never sets the flag.
- R6: A set flag stays set through any number of cycles until the host clears it.
- R7: Writing status address 0Ch with a 0 in a flag's bit clears that flag. Writing a 1 leaves it unchanged.
- R8: When a flag's set event and the host clear of that flag fall in the same cycle, the flag ends up set.
- R9: `irq_n` is low exactly when (alarm flag AND alarm enable) OR (periodic flag AND periodic enable). The alarm enable is bit 0 and the periodic enable is bit 1 of address 0Ah.
- R10: Address 0Ah reads back its two enable bits, and address 0Bh reads back the rate field. All other bits of these bytes, and every unmapped address, read as 0.
- R11: Reset clears the alarm time, the enables, the rate field and both flags, so `irq_n` is high after reset.
- R12: Loading the counter through `cnt_load` moves the next periodic flag to follow the loaded fractional count, because the rate match uses only the live count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sec_cnt | input | 32 | Live seconds count |
| frac_cnt | input | 12 | Live fractional count |
| tick | input | 1 | High for one cycle when the count has just advanced |
| cnt_load | input | 1 | High for one cycle when the host has just loaded the count |
| reg_addr | input | 4 | Register address |
| reg_wr | input | 1 | Write strobe |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for `reg_addr`, combinational |
| irq_n | output | 1 | Active-low interrupt |

## Verification
- **Flag timing.** A flag caused by a tick or a load is visible on the status byte and on `irq_n` in the cycle right after that event's clock edge.
- **Alarm write.** A flag caused by an alarm write appears one edge later than that, because the write edge first stores the byte and the following edge compares.
- **Same-cycle results.** Register readback follows `reg_addr` within the same cycle. A change of enable is seen on `irq_n` right after its write edge.
- **How checks sample.** The bench keeps a cycle-stepped expected state, updated at each rising edge from the inputs it drove. It drives inputs on the falling edge. It compares `irq_n` and `reg_rdata` one time step after driving them, so every value is taken midway between edges.

// File: rtl/tirq_pkg.sv
package tirq_pkg;
    // Register offsets; the alarm bytes run upward from ADR_ALARM_LO
    localparam logic [3:0] ADR_ALARM_LO = 4'h6;
    localparam logic [3:0] ADR_ENABLES  = 4'hA;
    localparam logic [3:0] ADR_RATE     = 4'hB;
    localparam logic [3:0] ADR_STATUS   = 4'hC;
    // Bit positions shared by the enable byte and the status byte
    localparam int BIT_ALM = 0;
    localparam int BIT_PER = 1;

    typedef struct packed {
        logic alm;
        logic per;
    } flag_pair_t;
endpackage

// File: rtl/tirq_alarm.sv
module tirq_alarm
    import tirq_pkg::*;
#(
    parameter int SEC_W  = 32,
    parameter int DATA_W = 8,
    parameter int ADDR_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [SEC_W-1:0]  sec,
    input  logic              tick,
    input  logic              cnt_load,
    output logic [SEC_W-1:0]  alarm,
    output logic              hit
);
    localparam int NBYTES = SEC_W / DATA_W;

    typedef struct packed {
        logic [SEC_W-1:0] alarm;
        logic             recheck;
    } alm_state_t;

    alm_state_t st_d, st_q;
    logic [NBYTES-1:0] lane_sel;

    // One decode per byte lane
    for (genvar k = 0; k < NBYTES; k++) begin : g_lane
        assign lane_sel[k] = wr && (addr == ADDR_W'(ADR_ALARM_LO) + ADDR_W'(k));
    end

    always_comb begin
        st_d = st_q;
        for (int k = 0; k < NBYTES; k++) begin
            if (lane_sel[k]) begin
                st_d.alarm[k*DATA_W +: DATA_W] = wdata;
            end
        end
        st_d.recheck = |lane_sel;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign alarm = st_q.alarm;
    assign hit   = (tick || cnt_load || st_q.recheck) && (sec == st_q.alarm);

    // Any alarm byte write schedules a compare at the next edge
    p_write_recheck_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (|lane_sel) |=> st_q.recheck);
    // A written byte is held until overwritten
    p_byte_store_r1: assert property (@(posedge clk) disable iff (!rst_n)
        lane_sel[0] |=> (st_q.alarm[DATA_W-1:0] == $past(wdata)));
    // A hit needs an exact match of the seconds count
    p_hit_match_r2: assert property (@(posedge clk) disable iff (!rst_n)
        hit |-> (sec == alarm));
endmodule

// File: rtl/tirq_rate.sv
module tirq_rate #(
    parameter int SEC_W  = 32,
    parameter int FRAC_W = 12,
    parameter int RATE_W = 4
) (
    input  logic [RATE_W-1:0] rate,
    input  logic              tick,
    input  logic [FRAC_W-1:0] frac,
    input  logic [SEC_W-1:0]  sec,
    output logic              hit
);
    // Rates 1..FRAC_W count fractional ticks, higher ones count whole seconds
    logic [FRAC_W-1:0] frac_mask;
    logic [SEC_W-1:0]  sec_mask;
    logic              active;
    int                r;

    always_comb begin
        r         = int'(rate);
        frac_mask = '0;
        sec_mask  = '0;
        active    = (r != 0);
        if (r == 0) begin
            frac_mask = '0;
        end else if (r <= FRAC_W) begin
            frac_mask = FRAC_W'((1 << (r - 1)) - 1);
        end else begin
            frac_mask = '1;
            sec_mask  = SEC_W'((1 << (r - FRAC_W - 1)) - 1);
        end
        hit = tick && active && ((frac & frac_mask) == '0) && ((sec & sec_mask) == '0);
    end
endmodule

// File: rtl/tirq_flags.sv
module tirq_flags
    import tirq_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              alm_set,
    input  logic              per_set,
    input  logic              clr_wr,
    input  logic [DATA_W-1:0] clr_data,
    input  logic              alm_en,
    input  logic              per_en,
    output flag_pair_t        flags,
    output logic              irq_n
);
    flag_pair_t fl_d, fl_q;
    logic clr_alm, clr_per;

    assign clr_alm = clr_wr && !clr_data[BIT_ALM];
    assign clr_per = clr_wr && !clr_data[BIT_PER];

    // A set event outranks a clear in the same cycle
    always_comb begin
        fl_d     = fl_q;
        fl_d.alm = alm_set || (fl_q.alm && !clr_alm);
        fl_d.per = per_set || (fl_q.per && !clr_per);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fl_q <= '0;
        end else begin
            fl_q <= fl_d;
        end
    end

    assign flags = fl_q;
    assign irq_n = !((fl_q.alm && alm_en) || (fl_q.per && per_en));

    p_alm_set_r2: assert property (@(posedge clk) disable iff (!rst_n)
        alm_set |=> flags.alm);
    p_per_set_wins_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (per_set && clr_per) |=> flags.per);
    p_alm_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (flags.alm && !clr_alm) |=> flags.alm);
    p_per_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_per && !per_set) |=> !flags.per);
    p_irq_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!alm_en && !per_en) |-> irq_n);
    p_irq_source_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !irq_n |-> (flags.alm || flags.per));
endmodule

// File: rtl/tirq_unit.sv
module tirq_unit
    import tirq_pkg::*;
#(
    parameter int SEC_W  = 32,
    parameter int FRAC_W = 12,
    parameter int RATE_W = 4,
    parameter int ADDR_W = 4,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [SEC_W-1:0]  sec_cnt,
    input  logic [FRAC_W-1:0] frac_cnt,
    input  logic              tick,
    input  logic              cnt_load,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic              reg_wr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    output logic              irq_n
);
    localparam int NBYTES = SEC_W / DATA_W;
    localparam int RATE_LSB = DATA_W - RATE_W;

    typedef struct packed {
        logic              alm_en;
        logic              per_en;
        logic [RATE_W-1:0] rate;
    } ctl_t;

    ctl_t ctl_d, ctl_q;
    logic [SEC_W-1:0] alarm;
    logic alm_hit, per_hit;
    flag_pair_t flags;

    always_comb begin
        ctl_d = ctl_q;
        if (reg_wr && reg_addr == ADDR_W'(ADR_ENABLES)) begin
            ctl_d.alm_en = reg_wdata[BIT_ALM];
            ctl_d.per_en = reg_wdata[BIT_PER];
        end
        if (reg_wr && reg_addr == ADDR_W'(ADR_RATE)) begin
            ctl_d.rate = reg_wdata[DATA_W-1:RATE_LSB];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctl_q <= '0;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    tirq_alarm #(.SEC_W(SEC_W), .DATA_W(DATA_W), .ADDR_W(ADDR_W)) i_alarm (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr       (reg_wr),
        .addr     (reg_addr),
        .wdata    (reg_wdata),
        .sec      (sec_cnt),
        .tick     (tick),
        .cnt_load (cnt_load),
        .alarm    (alarm),
        .hit      (alm_hit)
    );

    tirq_rate #(.SEC_W(SEC_W), .FRAC_W(FRAC_W), .RATE_W(RATE_W)) i_rate (
        .rate (ctl_q.rate),
        .tick (tick),
        .frac (frac_cnt),
        .sec  (sec_cnt),
        .hit  (per_hit)
    );

    tirq_flags #(.DATA_W(DATA_W)) i_flags (
        .clk      (clk),
        .rst_n    (rst_n),
        .alm_set  (alm_hit),
        .per_set  (per_hit),
        .clr_wr   (reg_wr && reg_addr == ADDR_W'(ADR_STATUS)),
        .clr_data (reg_wdata),
        .alm_en   (ctl_q.alm_en),
        .per_en   (ctl_q.per_en),
        .flags    (flags),
        .irq_n    (irq_n)
    );

    // Read mux
    always_comb begin
        reg_rdata = '0;
        for (int k = 0; k < NBYTES; k++) begin
            if (reg_addr == ADDR_W'(ADR_ALARM_LO) + ADDR_W'(k)) begin
                reg_rdata = alarm[k*DATA_W +: DATA_W];
            end
        end
        if (reg_addr == ADDR_W'(ADR_ENABLES)) begin
            reg_rdata[BIT_ALM] = ctl_q.alm_en;
            reg_rdata[BIT_PER] = ctl_q.per_en;
        end
        if (reg_addr == ADDR_W'(ADR_RATE)) begin
            reg_rdata[DATA_W-1:RATE_LSB] = ctl_q.rate;
        end
        if (reg_addr == ADDR_W'(ADR_STATUS)) begin
            reg_rdata[BIT_ALM] = flags.alm;
            reg_rdata[BIT_PER] = flags.per;
        end
    end

    // A zero rate never produces a periodic event
    p_rate_off_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_q.rate == '0) |-> !per_hit);
    // Periodic events only come with a tick
    p_per_on_tick_r4: assert property (@(posedge clk) disable iff (!rst_n)
        per_hit |-> tick);
    // Enable byte holds after a write to it
    p_enable_store_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr == ADDR_W'(ADR_ENABLES)) |=> (ctl_q.alm_en == $past(reg_wdata[BIT_ALM])));
endmodule

// File: tb/test_tirq_unit.sv
`timescale 1ns/1ps
module test_tirq_unit;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] sec_cnt = '0;
    logic [11:0] frac_cnt = '0;
    logic        tick = 1'b0;
    logic        cnt_load = 1'b0;
    logic [3:0]  reg_addr = '0;
    logic        reg_wr = 1'b0;
    logic [7:0]  reg_wdata = '0;
    logic [7:0]  reg_rdata;
    logic        irq_n;

    always #2.5 clk = ~clk;

    tirq_unit i_tirq_unit (
        .clk(clk), .rst_n(rst_n), .sec_cnt(sec_cnt), .frac_cnt(frac_cnt),
        .tick(tick), .cnt_load(cnt_load), .reg_addr(reg_addr), .reg_wr(reg_wr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq_n(irq_n)
    );

    int n_checks = 0;
    int n_fail = 0;
    bit finished = 0;
    string tag = "R11";

    // Expected state
    logic [31:0] m_alarm;
    logic        m_aie, m_pie, m_almf, m_pf, m_recheck;
    logic [3:0]  m_rate;

    function automatic bit rate_due(int p, logic [11:0] f, logic [31:0] s);
        if (p == 0) return 1'b0;
        if (p <= 12) return (int'(f) % (1 << (p - 1))) == 0;
        return (f == 12'd0) && ((s % (32'd1 << (p - 13))) == 0);
    endfunction

    function automatic logic [7:0] exp_read(logic [3:0] a);
        case (a)
            4'h6: return m_alarm[7:0];
            4'h7: return m_alarm[15:8];
            4'h8: return m_alarm[23:16];
            4'h9: return m_alarm[31:24];
            4'hA: return {6'b0, m_pie, m_aie};
            4'hB: return {m_rate, 4'b0};
            4'hC: return {6'b0, m_pf, m_almf};
            default: return 8'h00;
        endcase
    endfunction

    function automatic string read_tag(logic [3:0] a);
        if (a >= 4'h6 && a <= 4'h9) return "R1";
        if (a == 4'hA || a == 4'hB) return "R10";
        if (a == 4'hC) return tag;
        return "R10";
    endfunction

    task automatic check(string t, string what, int act, int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h at %0t", t, what, act, exp, $time);
        end
    endtask

    // One cycle: called at a falling edge, returns at the next falling edge
    task automatic step(bit tk, bit ld, logic [31:0] ld_sec, logic [11:0] ld_frac,
                        bit wr, logic [3:0] a, logic [7:0] wd);
        bit aset, pset;
        if (ld) begin
            sec_cnt = ld_sec; frac_cnt = ld_frac;
        end else if (tk) begin
            frac_cnt = frac_cnt + 12'd1;
            if (frac_cnt == 12'd0) sec_cnt = sec_cnt + 32'd1;
        end
        tick = tk && !ld; cnt_load = ld;
        reg_wr = wr; reg_addr = a; reg_wdata = wd;
        #1;
        check(read_tag(a), "reg_rdata", int'(reg_rdata), int'(exp_read(a)));
        check((tag == "R11") ? "R11" : "R9", "irq_n", int'(irq_n),
              int'(!((m_almf && m_aie) || (m_pf && m_pie))));
        aset = (tick || cnt_load || m_recheck) && (sec_cnt == m_alarm);
        pset = tick && rate_due(int'(m_rate), frac_cnt, sec_cnt);
        @(posedge clk);
        m_almf = aset || (m_almf && !(wr && a == 4'hC && !wd[0]));
        m_pf   = pset || (m_pf && !(wr && a == 4'hC && !wd[1]));
        m_recheck = wr && a >= 4'h6 && a <= 4'h9;
        if (wr) begin
            case (a)
                4'h6: m_alarm[7:0] = wd;
                4'h7: m_alarm[15:8] = wd;
                4'h8: m_alarm[23:16] = wd;
                4'h9: m_alarm[31:24] = wd;
                4'hA: begin m_aie = wd[0]; m_pie = wd[1]; end
                4'hB: m_rate = wd[7:4];
                default: ;
            endcase
        end
        @(negedge clk);
    endtask

    task automatic idle(logic [3:0] a);
        step(0, 0, '0, '0, 0, a, 8'h00);
    endtask
    task automatic wr_reg(logic [3:0] a, logic [7:0] d);
        step(0, 0, '0, '0, 1, a, d);
    endtask
    task automatic ticks(int n, logic [3:0] a);
        for (int i = 0; i < n; i++) step(1, 0, '0, '0, 0, a, 8'h00);
    endtask
    task automatic load(logic [31:0] s, logic [11:0] f);
        step(0, 1, s, f, 0, 4'hC, 8'h00);
    endtask
    task automatic set_alarm(logic [31:0] v);
        for (int b = 0; b < 4; b++) wr_reg(4'(6 + b), v[b*8 +: 8]);
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_fail++;
            $display("FAIL watchdog expired");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin : main
        logic [3:0] a;
        logic [7:0] d;
        m_alarm = '0; m_aie = 0; m_pie = 0; m_almf = 0; m_pf = 0; m_recheck = 0; m_rate = '0;
        repeat (4) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        // R11: reset values
        tag = "R11";
        for (int i = 0; i < 16; i++) idle(4'(i));
        // R1: alarm bytes little-endian, readback
        tag = "R1";
        set_alarm(32'h0000_0105);
        for (int i = 6; i < 10; i++) idle(4'(i));
        check("R1", "alarm byte 6", int'(exp_read(4'h6)), 8'h05);
        // R10: enable and rate bytes, unused bits zero
        tag = "R10";
        wr_reg(4'hA, 8'hFD); idle(4'hA);
        wr_reg(4'hB, 8'h0F); idle(4'hB);
        // R2: alarm via ticks across a second boundary
        tag = "R2";
        load(32'h0000_0104, 12'd4094);
        ticks(3, 4'hC);
        check("R2", "alarm flag after match", int'(m_almf), 1);
        // R6: sticky while time moves on
        tag = "R6";
        ticks(20, 4'hC);
        // R7: writing 1 keeps it, writing 0 clears
        tag = "R7";
        wr_reg(4'hC, 8'hFF); idle(4'hC);
        wr_reg(4'hC, 8'hFE); idle(4'hC);
        // R3: alarm written to current seconds sets without a tick
        tag = "R3";
        set_alarm(sec_cnt);
        idle(4'hC); idle(4'hC);
        // R4: rate 3 -> every 4 ticks, periodic enable only
        tag = "R4";
        wr_reg(4'hC, 8'h00); wr_reg(4'hA, 8'h02); wr_reg(4'hB, 8'h30);
        load(32'h10, 12'd1);
        for (int i = 0; i < 12; i++) begin
            ticks(1, 4'hC);
            wr_reg(4'hC, 8'hFD);
        end
        for (int r = 1; r <= 12; r++) begin
            wr_reg(4'hB, 8'(r << 4));
            load(32'h20, 12'hFF0 - 12'(r));
            ticks(40, 4'hC);
            wr_reg(4'hC, 8'h00);
        end
        // R8: set and clear in the same cycle
        tag = "R8";
        wr_reg(4'hB, 8'h20);
        load(32'h30, 12'd1);
        step(1, 0, '0, '0, 1, 4'hC, 8'h00);
        check("R8", "periodic flag kept over clear", int'(m_pf), 1);
        idle(4'hC);
        // R5: second-based rates and rate 0
        tag = "R5";
        for (int r = 13; r <= 15; r++) begin
            wr_reg(4'hB, 8'(r << 4));
            for (int s = 0; s < 6; s++) begin
                load(32'h40 + 32'(s), 12'hFFE);
                ticks(3, 4'hC);
                wr_reg(4'hC, 8'h00);
            end
        end
        wr_reg(4'hB, 8'h00);
        load(32'h50, 12'hFFE);
        ticks(30, 4'hC);
        // R12: loading the count moves the next periodic event
        tag = "R12";
        wr_reg(4'hB, 8'h50);
        load(32'h60, 12'd5);
        ticks(4, 4'hC);
        load(32'h60, 12'd15);
        ticks(2, 4'hC);
        check("R12", "periodic flag after load", int'(m_pf), 1);
        // R9: gating of both sources
        tag = "R9";
        set_alarm(sec_cnt); idle(4'hC);
        wr_reg(4'hA, 8'h00); idle(4'hC);
        wr_reg(4'hA, 8'h01); idle(4'hC);
        wr_reg(4'hA, 8'h03); idle(4'hC);
        wr_reg(4'hC, 8'h02); idle(4'hC);
        // Random phase, fixed seed
        void'($urandom(32'h1B2C));
        for (int i = 0; i < 6000; i++) begin
            bit tk, ld, wr;
            tk = ($urandom % 3) != 0;
            ld = ($urandom % 50) == 0;
            wr = ($urandom % 4) == 0;
            a = 4'($urandom % 16);
            if (wr) a = 4'(6 + ($urandom % 7));
            d = 8'($urandom);
            if (wr && a >= 4'h6 && a <= 4'h9) begin
                logic [31:0] near;
                near = sec_cnt + 32'($urandom % 3);
                d = near[(int'(a) - 6) * 8 +: 8];
            end
            step(tk, ld, sec_cnt + 32'($urandom % 2), 12'hFF0 + 12'($urandom % 16), wr, a, d);
        end
        finished = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule